// File: doc/BRIEF.md
# Two-Channel Masked Address Breakpoint Counter

This block watches the memory accesses of a CPU and raises a breakpoint request after a chosen number of matching accesses. Each access presented on the bus side (address, a read or write flag and a valid strobe) is captured into an address latch. On the following cycle, each of two independent channels compares the latched address with its own base address. Only the bit positions enabled by the channel's mask take part in the comparison. The channel then qualifies the result with an access-direction condition and a match-sense condition taken from a shared control register.

Each channel owns a 16-bit down-counter. Software loads it with the number of qualifying events wanted, minus one. Every qualifying event takes one from a non-zero count. An event that arrives while the count is already zero sets the channel's sticky fired flag, and the request output is the OR of both fired flags. A counter write is the only action that arms a channel. Writing a channel's base, its mask or the control register disarms that channel until its counter is written again, so no stale event history carries over into a new setup. A simple register port with a write strobe and combinational read data gives access to all settings in place of a serial debug link.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, all eight registers read zero, both channels are disarmed and `brk_req` is low.
- R2: A channel sees an address hit when `((latched_addr ^ base) & mask) == 0`, where a 1 in the mask means the bit is compared. The match-sense field (control bits [9:5] for channel 0, bits [25:21] for channel 1) selects the qualifying result: 1 qualifies on a hit, 2 qualifies on a miss, and any other value never qualifies.
- R3: The direction field (control bits [4:0] for channel 0, bits [20:16] for channel 1) selects the accesses that count: 1 counts reads only (`bus_write`=0), 2 counts writes only, 3 counts both. The values 0 and 4 to 31 disable the channel.
- R4: A qualifying event on an armed channel whose count is non-zero reduces the count by exactly one. The count never goes below zero.
- R5: A qualifying event on an armed channel whose count is zero sets that channel's fired flag. An access sampled at clock edge k is counted at edge k+1, so `brk_req` is high after edge k+1 and not before.
- R6: `brk_req` is the OR of the two fired flags. A fired flag stays set until that channel's counter is written or its status clear bit is written.
- R7: A write to a channel's base (select 0 or 3), its mask (select 1 or 4) or the control register (select 6, which affects both channels) disarms that channel. A disarmed channel neither counts down nor fires.
- R8: A counter write (select 2 for channel 0, select 5 for channel 1) loads bits [15:0], arms the channel and clears its fired flag. An event counted at the same edge is discarded.
- R9: Read data is combinational on `cfg_addr`. Base and mask read back in full, the counter reads zero-extended, and control reads back only bits [9:0] and [25:16] with zeros elsewhere. Status (select 7) reads fired flags in bits [1:0] and armed flags in bits [3:2], with the channel number as the bit offset.
- R10: Writing status with bit c set clears the fired flag of channel c. A fired flag set by an event at the same edge wins over the clear.
- R11: The channels are independent: an event, fire or clear on one channel leaves the other channel's count and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Access address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| brk_req | output | 1 | Breakpoint request toward the CPU |

## Verification
Read data is due within the same cycle as the select. Register writes show up on the reads of the next cycle. An access sampled at edge k changes the counts, flags and `brk_req` only at edge k+1, so a check made just before edge k+1 must still see the old values. The bench drives every input on the falling edge. It samples one time unit later, before the next rising edge. A reference model advances once per rising edge using the inputs that edge sampled, so each comparison sees exactly the registers updated so far. The directed sequences insert an idle cycle between an access and the read that shows its effect, and one case checks `brk_req` explicitly in the cycle before the fire.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int NUM_CH       = 2;
  localparam int DATA_W       = 32;
  localparam int RSEL_W       = 3;
  localparam int SLOTS_PER_CH = 3;
  localparam int CH_FIELD_POS = 16;

  typedef enum logic [1:0] {
    SLOT_BASE  = 2'd0,
    SLOT_MASK  = 2'd1,
    SLOT_COUNT = 2'd2
  } slot_e;

  localparam logic [RSEL_W-1:0] RSEL_CTRL = 3'd6;
  localparam logic [RSEL_W-1:0] RSEL_STAT = 3'd7;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h03FF_03FF;

  localparam logic [4:0] DIR_RD  = 5'd1;
  localparam logic [4:0] DIR_WR  = 5'd2;
  localparam logic [4:0] DIR_ANY = 5'd3;

  localparam logic [4:0] SENSE_HIT  = 5'd1;
  localparam logic [4:0] SENSE_MISS = 5'd2;

  typedef struct packed {
    logic [4:0] sense;
    logic [4:0] dir;
  } ch_ctrl_t;

  function automatic logic [RSEL_W-1:0] slot_sel(input int ch, input slot_e s);
    return RSEL_W'(ch * SLOTS_PER_CH + int'(s));
  endfunction

  function automatic ch_ctrl_t ctrl_field(input logic [DATA_W-1:0] ctrl, input int ch);
    return ch_ctrl_t'(ctrl[ch*CH_FIELD_POS +: 10]);
  endfunction

endpackage

// File: rtl/bkpt_event_qual.sv
module bkpt_event_qual
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  ch_ctrl_t          ctrl_i,
  output logic              event_o
);

  logic addr_hit;
  logic dir_ok;
  logic sense_ok;

  always_comb begin
    addr_hit = (((acc_addr_i ^ base_i) & mask_i) == '0);

    case (ctrl_i.dir)
      DIR_RD:  dir_ok = ~acc_write_i;
      DIR_WR:  dir_ok = acc_write_i;
      DIR_ANY: dir_ok = 1'b1;
      default: dir_ok = 1'b0;
    endcase

    case (ctrl_i.sense)
      SENSE_HIT:  sense_ok = addr_hit;
      SENSE_MISS: sense_ok = ~addr_hit;
      default:    sense_ok = 1'b0;
    endcase

    event_o = acc_valid_i & dir_ok & sense_ok;
  end

endmodule

// File: rtl/bkpt_event_ctr.sv
module bkpt_event_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             disarm_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             fired_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             fired_q, fired_d;
  logic             live_ev;
  logic             at_zero;
  logic             upd_en;

  always_comb begin
    live_ev = event_i & armed_q;
    at_zero = (cnt_q == '0);
    upd_en  = load_i | disarm_i | live_ev | clr_i;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    fired_d = fired_q;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
      fired_d = 1'b0;
    end else if (disarm_i) begin
      armed_d = 1'b0;
    end else begin
      if (live_ev && !at_zero) begin
        cnt_d = cnt_q - CNT_ONE;
      end
      if (live_ev && at_zero) begin
        fired_d = 1'b1;
      end else if (clr_i) begin
        fired_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      fired_q <= fired_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
  assign fired_o = fired_q;

endmodule

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [RSEL_W-1:0]              cfg_addr,
  input  logic [DATA_W-1:0]              cfg_wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_CH-1:0]              armed_i,
  input  logic [NUM_CH-1:0]              fired_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  mask_o,
  output ch_ctrl_t [NUM_CH-1:0]          ctrl_o,
  output logic [NUM_CH-1:0]              cnt_ld_o,
  output logic [NUM_CH-1:0]              setup_wr_o,
  output logic [NUM_CH-1:0]              clr_o,
  output logic [DATA_W-1:0]              cfg_rdata
);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = cfg_we && (cfg_addr == RSEL_CTRL);
    ctrl_d  = cfg_wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [RSEL_W-1:0] SEL_BASE = slot_sel(c, SLOT_BASE);
    localparam logic [RSEL_W-1:0] SEL_MASK = slot_sel(c, SLOT_MASK);
    localparam logic [RSEL_W-1:0] SEL_CNT  = slot_sel(c, SLOT_COUNT);

    logic [ADDR_W-1:0] base_q, base_d, mask_q, mask_d;
    logic              base_en, mask_en;

    always_comb begin
      base_en = cfg_we && (cfg_addr == SEL_BASE);
      mask_en = cfg_we && (cfg_addr == SEL_MASK);
      base_d  = cfg_wdata[ADDR_W-1:0];
      mask_d  = cfg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
      end else if (base_en) begin
        base_q <= base_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
      end else if (mask_en) begin
        mask_q <= mask_d;
      end
    end

    assign base_o[c]     = base_q;
    assign mask_o[c]     = mask_q;
    assign ctrl_o[c]     = ctrl_field(ctrl_q, c);
    assign cnt_ld_o[c]   = cfg_we && (cfg_addr == SEL_CNT);
    assign setup_wr_o[c] = base_en | mask_en | ctrl_en;
    assign clr_o[c]      = cfg_we && (cfg_addr == RSEL_STAT) && cfg_wdata[c];
  end

  always_comb begin
    cfg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfg_addr == slot_sel(c, SLOT_BASE))  cfg_rdata = DATA_W'(base_o[c]);
      if (cfg_addr == slot_sel(c, SLOT_MASK))  cfg_rdata = DATA_W'(mask_o[c]);
      if (cfg_addr == slot_sel(c, SLOT_COUNT)) cfg_rdata = DATA_W'(cnt_i[c]);
    end
    if (cfg_addr == RSEL_CTRL) cfg_rdata = ctrl_q;
    if (cfg_addr == RSEL_STAT) cfg_rdata = DATA_W'({armed_i, fired_i});
  end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              brk_req
);

  logic              lat_valid_q, lat_valid_d;
  logic              lat_write_q, lat_write_d;
  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;

  always_comb begin
    lat_valid_d = bus_valid;
    lat_write_d = bus_write;
    lat_addr_d  = bus_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_valid_q <= 1'b0;
    end else begin
      lat_valid_q <= lat_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write_q <= 1'b0;
      lat_addr_q  <= '0;
    end else if (bus_valid) begin
      lat_write_q <= lat_write_d;
      lat_addr_q  <= lat_addr_d;
    end
  end

  logic [NUM_CH-1:0][ADDR_W-1:0] ch_base;
  logic [NUM_CH-1:0][ADDR_W-1:0] ch_mask;
  ch_ctrl_t [NUM_CH-1:0]         ch_ctrl;
  logic [NUM_CH-1:0]             ch_load;
  logic [NUM_CH-1:0]             ch_setup_wr;
  logic [NUM_CH-1:0]             ch_clr;
  logic [NUM_CH-1:0]             ch_event;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NUM_CH-1:0]             ch_armed;
  logic [NUM_CH-1:0]             ch_fired;

  bkpt_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cnt_i      (ch_cnt),
    .armed_i    (ch_armed),
    .fired_i    (ch_fired),
    .base_o     (ch_base),
    .mask_o     (ch_mask),
    .ctrl_o     (ch_ctrl),
    .cnt_ld_o   (ch_load),
    .setup_wr_o (ch_setup_wr),
    .clr_o      (ch_clr),
    .cfg_rdata  (cfg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    bkpt_event_qual #(
      .ADDR_W (ADDR_W)
    ) u_qual (
      .acc_valid_i (lat_valid_q),
      .acc_write_i (lat_write_q),
      .acc_addr_i  (lat_addr_q),
      .base_i      (ch_base[c]),
      .mask_i      (ch_mask[c]),
      .ctrl_i      (ch_ctrl[c]),
      .event_o     (ch_event[c])
    );

    bkpt_event_ctr #(
      .CNT_W (CNT_W)
    ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .event_i    (ch_event[c]),
      .load_i     (ch_load[c]),
      .load_val_i (cfg_wdata[CNT_W-1:0]),
      .disarm_i   (ch_setup_wr[c]),
      .clr_i      (ch_clr[c]),
      .cnt_o      (ch_cnt[c]),
      .armed_o    (ch_armed[c]),
      .fired_o    (ch_fired[c])
    );
  end

  assign brk_req = |ch_fired;

endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk
  import bkpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [RSEL_W-1:0]            cfg_addr,
  input logic [DATA_W-1:0]            cfg_wdata,
  input logic                         brk_req,
  input logic [NUM_CH-1:0]            armed,
  input logic [NUM_CH-1:0]            fired,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);
  localparam logic [RSEL_W-1:0] CNT0_S = slot_sel(0, SLOT_COUNT);
  localparam logic [RSEL_W-1:0] CNT1_S = slot_sel(1, SLOT_COUNT);

  // R6: the request only drops after a counter write or a status write
  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_req) |-> ($past(cfg_we) &&
      ($past(cfg_addr) == RSEL_STAT || $past(cfg_addr) == CNT0_S || $past(cfg_addr) == CNT1_S)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [RSEL_W-1:0] S_BASE = slot_sel(c, SLOT_BASE);
    localparam logic [RSEL_W-1:0] S_MASK = slot_sel(c, SLOT_MASK);
    localparam logic [RSEL_W-1:0] S_CNT  = slot_sel(c, SLOT_COUNT);

    assert_load_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == S_CNT) |=>
        (armed[c] && !fired[c] && cnt[c] == $past(cfg_wdata[CNT_W-1:0])));

    assert_setup_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_addr == S_BASE || cfg_addr == S_MASK || cfg_addr == RSEL_CTRL)) |=> !armed[c]);

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we && cfg_addr == S_CNT) && cnt[c] != $past(cnt[c])) |->
        (cnt[c] == $past(cnt[c]) - ONE_C));

    assert_fire_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fired[c]) |-> ($past(cnt[c]) == '0 && $past(armed[c])));

    assert_fire_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fired[c] && !(cfg_we && (cfg_addr == S_CNT || (cfg_addr == RSEL_STAT && cfg_wdata[c]))))
        |=> fired[c]);
  end

endmodule

bind bkpt_match_unit bkpt_match_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .brk_req   (brk_req),
  .armed     (ch_armed),
  .fired     (ch_fired),
  .cnt       (ch_cnt)
);

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        brk_req;

  int n_tests;
  int n_fail;
  bit done;

  bkpt_match_unit u_bkpt_match_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .brk_req   (brk_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model state
  logic [31:0] m_base [2];
  logic [31:0] m_mask [2];
  logic [15:0] m_cnt  [2];
  logic        m_arm  [2];
  logic        m_fire [2];
  logic [31:0] m_ctrl;
  logic        m_lv, m_lw;
  logic [31:0] m_la;

  function automatic logic mqual(input int ch);
    logic [4:0] dir, sense;
    logic hit, dok, sok;
    dir   = m_ctrl[ch*16 +: 5];
    sense = m_ctrl[ch*16+5 +: 5];
    hit   = (((m_la ^ m_base[ch]) & m_mask[ch]) == 32'd0);
    dok   = (dir == 5'd1 && !m_lw) || (dir == 5'd2 && m_lw) || (dir == 5'd3);
    sok   = (sense == 5'd1 && hit) || (sense == 5'd2 && !hit);
    return m_lv && dok && sok;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_base[0];
      3'd1: return m_mask[0];
      3'd2: return {16'd0, m_cnt[0]};
      3'd3: return m_base[1];
      3'd4: return m_mask[1];
      3'd5: return {16'd0, m_cnt[1]};
      3'd6: return m_ctrl;
      default: return {28'd0, m_arm[1], m_arm[0], m_fire[1], m_fire[0]};
    endcase
  endfunction

  task automatic mstep(input logic bv, input logic [31:0] ba, input logic bw,
                       input logic we, input logic [2:0] wa, input logic [31:0] wd);
    logic ev [2];
    for (int c = 0; c < 2; c++) ev[c] = mqual(c);
    for (int c = 0; c < 2; c++) begin
      int sb;
      sb = c * 3;
      if (we && wa == sb + 2) begin
        m_cnt[c] = wd[15:0];
        m_arm[c] = 1'b1;
        m_fire[c] = 1'b0;
      end else if (we && (wa == sb || wa == sb + 1 || wa == 6)) begin
        m_arm[c] = 1'b0;
      end else begin
        if (ev[c] && m_arm[c] && m_cnt[c] == 16'd0) m_fire[c] = 1'b1;
        else if (we && wa == 3'd7 && wd[c]) m_fire[c] = 1'b0;
        if (ev[c] && m_arm[c] && m_cnt[c] != 16'd0) m_cnt[c] = m_cnt[c] - 16'd1;
      end
    end
    if (we) begin
      case (wa)
        3'd0: m_base[0] = wd;
        3'd1: m_mask[0] = wd;
        3'd3: m_base[1] = wd;
        3'd4: m_mask[1] = wd;
        3'd6: m_ctrl = wd & 32'h03FF_03FF;
        default: ;
      endcase
    end
    m_lv = bv;
    if (bv) begin
      m_la = ba;
      m_lw = bw;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one cycle: drive on the falling edge, compare, advance the model at the rising edge
  task automatic cyc(input logic bv, input logic [31:0] ba, input logic bw,
                     input logic we, input logic [2:0] wa, input logic [31:0] wd,
                     input string tag, input bit lit_en, input logic [31:0] lit,
                     input int req_exp);
    @(negedge clk);
    bus_valid = bv;
    bus_addr  = ba;
    bus_write = bw;
    cfg_we    = we;
    cfg_addr  = wa;
    cfg_wdata = wd;
    #1;
    chk({tag, " rdata"}, cfg_rdata, mread(wa));
    chk({tag, " brk_req"}, {31'd0, brk_req}, {31'd0, m_fire[0] | m_fire[1]});
    if (lit_en) chk({tag, " literal"}, cfg_rdata, lit);
    if (req_exp >= 0) chk({tag, " literal brk_req"}, {31'd0, brk_req}, 32'(req_exp));
    @(posedge clk);
    #1;
    mstep(bv, ba, bw, we, wa, wd);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b0, 32'd0, 1'b0, 1'b1, a, d, "R9 write", 1'b0, 32'd0, -1);
  endtask

  task automatic acc(input logic [31:0] a, input logic w);
    cyc(1'b1, a, w, 1'b0, 3'd7, 32'd0, "R5 access", 1'b0, 32'd0, -1);
  endtask

  task automatic idle();
    cyc(1'b0, 32'd0, 1'b0, 1'b0, 3'd7, 32'd0, "R6 idle", 1'b0, 32'd0, -1);
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input int req, input string tag);
    cyc(1'b0, 32'd0, 1'b0, 1'b0, a, 32'd0, tag, 1'b1, exp, req);
  endtask

  function automatic logic [31:0] rnd_data(input logic [2:0] a);
    case (a)
      3'd0, 3'd3: return 32'h0000_1000 | ($urandom & 32'hFF);
      3'd1, 3'd4: begin
        case ($urandom % 4)
          0: return 32'hFFFF_FFFF;
          1: return 32'hFFFF_FF00;
          2: return 32'hFFFF_FFF0;
          default: return 32'h0000_0000;
        endcase
      end
      3'd2, 3'd5: return $urandom % 4;
      3'd6: return {6'd0, 5'($urandom % 4), 5'($urandom % 6), 6'd0, 5'($urandom % 4), 5'($urandom % 6)};
      default: return $urandom % 4;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    seed    = $urandom(32'h5EED_1234);
    for (int c = 0; c < 2; c++) begin
      m_base[c] = 0; m_mask[c] = 0; m_cnt[c] = 0; m_arm[c] = 0; m_fire[c] = 0;
    end
    m_ctrl = 0; m_lv = 0; m_lw = 0; m_la = 0;
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_addr = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 8; a++) peek(3'(a), 32'd0, 0, "R1 reset");

    // channel 0: hit on any direction, count 2
    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'hFFFF_FF00);
    wr(3'd6, 32'h0000_0023);
    wr(3'd2, 32'd2);
    peek(3'd0, 32'h0000_1000, 0, "R9 base readback");
    peek(3'd6, 32'h0000_0023, 0, "R9 control readback");
    acc(32'h0000_1034, 1'b0); idle();
    peek(3'd2, 32'd1, 0, "R4 decrement");
    acc(32'h0000_3034, 1'b0); idle();
    peek(3'd2, 32'd1, 0, "R2 masked bit differs");
    acc(32'h0000_10FF, 1'b1); idle();
    peek(3'd2, 32'd0, 0, "R4 decrement to zero");
    acc(32'h0000_1000, 1'b0);
    peek(3'd7, 32'h4, 0, "R5 not yet fired");
    peek(3'd7, 32'h5, 1, "R5 fired status");
    idle(); idle(); idle();
    peek(3'd2, 32'd0, 1, "R6 request held, count stays zero");
    wr(3'd7, 32'h1);
    peek(3'd7, 32'h4, 0, "R10 status clear");

    // R3: direction selection
    wr(3'd6, 32'h0000_0021); wr(3'd2, 32'd0);
    acc(32'h0000_1000, 1'b1); idle();
    peek(3'd7, 32'h4, 0, "R3 read-only ignores write");
    acc(32'h0000_1000, 1'b0); idle();
    peek(3'd7, 32'h5, 1, "R3 read-only fires on read");
    wr(3'd6, 32'h0000_0022); wr(3'd2, 32'd0);
    acc(32'h0000_1000, 1'b0); idle();
    peek(3'd7, 32'h4, 0, "R3 write-only ignores read");
    acc(32'h0000_1000, 1'b1); idle();
    peek(3'd7, 32'h5, 1, "R3 write-only fires on write");
    wr(3'd6, 32'h0000_0025); wr(3'd2, 32'd0);
    acc(32'h0000_1000, 1'b0); acc(32'h0000_1000, 1'b1); idle();
    peek(3'd7, 32'h4, 0, "R3 reserved direction disables");

    // R2: sense selection
    wr(3'd6, 32'h0000_0063); wr(3'd2, 32'd0);
    acc(32'h0000_1000, 1'b0); acc(32'h0000_5000, 1'b0); idle();
    peek(3'd7, 32'h4, 0, "R2 reserved sense disables");
    wr(3'd6, 32'h0000_0043); wr(3'd2, 32'd0);
    acc(32'h0000_1010, 1'b0); idle();
    peek(3'd7, 32'h4, 0, "R2 miss sense ignores hit");
    acc(32'h0000_3000, 1'b0); idle();
    peek(3'd7, 32'h5, 1, "R2 miss sense fires");

    // R7: setup write disarms
    wr(3'd6, 32'h0000_0023); wr(3'd2, 32'd5);
    wr(3'd0, 32'h0000_1000);
    acc(32'h0000_1000, 1'b0); idle();
    peek(3'd2, 32'd5, 0, "R7 disarmed no decrement");
    peek(3'd7, 32'h0, 0, "R7 disarmed status");

    // R8: counter write beats a same-edge event
    wr(3'd2, 32'd5);
    acc(32'h0000_1000, 1'b0);
    wr(3'd2, 32'd3);
    idle();
    peek(3'd2, 32'd3, 0, "R8 load discards event");

    // R11: channel 1 independent of channel 0
    wr(3'd3, 32'h0000_5500);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0022_0023);
    wr(3'd5, 32'd0);
    wr(3'd2, 32'd7);
    acc(32'h0000_5500, 1'b1); idle();
    peek(3'd7, 32'hE, 1, "R11 only channel 1 fired");
    peek(3'd2, 32'd7, 1, "R11 channel 0 count untouched");
    wr(3'd7, 32'h2);
    peek(3'd7, 32'hC, 0, "R10 clear channel 1");

    // constrained random mix, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      logic        bv, bw, we;
      logic [31:0] ba;
      logic [2:0]  wa;
      bv = ($urandom % 3) != 0;
      bw = $urandom % 2;
      ba = (($urandom % 8) == 0) ? (32'h0000_2000 | ($urandom & 32'hFFF))
                                 : (32'h0000_1000 | ($urandom & 32'hFF));
      we = ($urandom % 6) == 0;
      wa = 3'($urandom % 8);
      cyc(bv, ba, bw, we, wa, we ? rnd_data(wa) : 32'd0, "R9 R6 random", 1'b0, 32'd0, -1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule